// File: doc/BRIEF.md
# Debug Status and Control Register

This block holds the 32-bit status and control word of a processor's debug unit. It keeps three kinds of state. The first is a set of read/write control fields: the access mode, the halting and monitor enables, instruction execute enable, user access disable, interrupt disable, acknowledge force and the entry cause. The second is a set of sticky flags: instruction progress and three exception flags that record events seen while halted. The third is the live core state: halted, restarted, abort-discard and non-secure status. The core drives single-cycle event pulses into it. The authentication enables shape what the enable bits read back as.

Software writes the word through a plain write strobe and data bus. The sticky flags cannot be written. They are cleared only by a separate run-control word, whose bit 3 clears the progress flag and whose bit 2 clears the three exception flags. The block drives an interrupt mask to the core, and drives acknowledge and trigger outputs to the system. Both follow the halted state unless the acknowledge-force bit is set. The read value is combinational from the stored state and the live inputs.

Top module: `dbg_stat_ctl`

## Requirements
- R1: After reset the read word is 0x00000002, and irq_mask, dbg_ack and dbg_trig are 0.
- R2: Bit 25 (progress flag) reads 1 from the cycle after any retire pulse. It stays 1 until a run-control write with bit 3 set. If a retire pulse arrives in the same cycle as that clear, the flag stays set.
- R3: Bits 8, 7 and 6 (undefined, asynchronous-abort and synchronous-abort flags) are set by their event pulses only while bit 0 reads 1. Events outside debug state leave them at 0.
- R4: A run-control write with bit 2 set clears bits 8, 7 and 6. A run-control write with only bit 3 set leaves them unchanged. Bit 2 does not clear bit 25.
- R5: Bit 19 (abort discard) reads 1 exactly while the core is halted. An asynchronous abort during that time still sets bit 7.
- R6: Bits 15 (monitor enable) and 14 (halting enable) read 0 while dbg_en is low. They read their stored values again once dbg_en is high.
- R7: Bit 16 reads the inverse of (dbg_en AND sec_inv_en). Bit 17 reads the inverse of ((ninv_en OR dbg_en) AND (sec_ninv_en OR sec_inv_en)).
- R8: While bit 10 is 1, dbg_ack and dbg_trig are 1. Otherwise both equal bit 0.
- R9: A halt pulse while not halted makes bits 1:0 read 01 from the next cycle. A restart pulse while halted makes them read 10. A halt pulse while halted and a restart pulse while not halted have no effect.
- R10: On halt entry, bits 5:2 load halt_cause. The codes are 0000 run-control request, 0001 breakpoint, 0100 external request, 0101 vector catch and 1010 watchpoint. The field is also writable, and halt entry wins over a write in the same cycle.
- R11: A register write stores bits 21:20, 15:10 and 5:2. All other bits ignore writes. Bits 31:26, 24, 23:22 and 9 always read 0.
- R12: irq_mask equals bit 11 of the read word.
- R13: Bit 18 reads the live nonsecure input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| rctl_wr_en | input | 1 | Run-control write strobe |
| rctl_wr_data | input | RCTL_W | Run-control data; bit 2 clears exception flags, bit 3 clears progress flag |
| retire | input | 1 | Instruction retired pulse |
| undef_evt | input | 1 | Undefined instruction exception pulse |
| sync_abort | input | 1 | Synchronous data abort pulse |
| async_abort | input | 1 | Asynchronous abort pulse |
| halt_evt | input | 1 | Debug state entry pulse |
| halt_cause | input | 4 | Entry cause code captured on halt entry |
| restart_evt | input | 1 | Debug state exit pulse |
| dbg_en | input | 1 | Invasive debug enable |
| ninv_en | input | 1 | Noninvasive debug enable |
| sec_inv_en | input | 1 | Secure invasive debug enable |
| sec_ninv_en | input | 1 | Secure noninvasive debug enable |
| nonsecure | input | 1 | Core is in non-secure state |
| reg_rd_data | output | 32 | Register read value |
| irq_mask | output | 1 | Interrupt mask to the core |
| dbg_ack | output | 1 | Debug acknowledge |
| dbg_trig | output | 1 | Debug trigger |

## Verification
The bench builds the block with its default RCTL_W of 32. Run-control words therefore carry bits 2 and 3 at their real positions, and the bench can also send wider words whose unused upper bits must have no effect. Since the bit layout is fixed, the default build covers all of the field behaviour. That includes set-versus-clear collisions on the flags, halt entry colliding with a cause write, and every authentication combination that moves bits 14 to 17.

// File: rtl/dbg_stat_pkg.sv
package dbg_stat_pkg;

    localparam int REG_W    = 32;
    localparam int CAUSE_W  = 4;
    localparam int MODE_W   = 2;
    localparam int NUM_EXC  = 3;

    // read-word bit positions
    localparam int P_ADV      = 25;
    localparam int P_MODE_LO  = 20;
    localparam int P_DISCARD  = 19;
    localparam int P_NS       = 18;
    localparam int P_NINV_DIS = 17;
    localparam int P_INV_DIS  = 16;
    localparam int P_MON_EN   = 15;
    localparam int P_HALT_EN  = 14;
    localparam int P_EXEC_EN  = 13;
    localparam int P_USR_DIS  = 12;
    localparam int P_IRQ_DIS  = 11;
    localparam int P_ACK_FRC  = 10;
    localparam int P_UNDEF    = 8;
    localparam int P_ASYNC    = 7;
    localparam int P_SYNC     = 6;
    localparam int P_CAUSE_LO = 2;
    localparam int P_RESTART  = 1;
    localparam int P_HALTED   = 0;

    // run-control clear positions
    localparam int RC_EXC_BIT = 2;
    localparam int RC_ADV_BIT = 3;

    // exception flag indices
    localparam int EX_UNDEF = 0;
    localparam int EX_ASYNC = 1;
    localparam int EX_SYNC  = 2;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_RUNCTL   = 4'b0000,
        CAUSE_BKPT     = 4'b0001,
        CAUSE_EXT_HALT = 4'b0100,
        CAUSE_VCATCH   = 4'b0101,
        CAUSE_WATCH    = 4'b1010
    } cause_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              mon_en;
        logic              halt_en;
        logic              exec_en;
        logic              usr_dis;
        logic              irq_dis;
        logic              ack_force;
    } ctrl_t;

    typedef struct packed {
        logic dbg_en;
        logic ninv_en;
        logic sec_inv_en;
        logic sec_ninv_en;
    } auth_t;

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.mode      = w[P_MODE_LO +: MODE_W];
        c.mon_en    = w[P_MON_EN];
        c.halt_en   = w[P_HALT_EN];
        c.exec_en   = w[P_EXEC_EN];
        c.usr_dis   = w[P_USR_DIS];
        c.irq_dis   = w[P_IRQ_DIS];
        c.ack_force = w[P_ACK_FRC];
        return c;
    endfunction

    function automatic logic inv_disabled(input auth_t a);
        return !(a.dbg_en && a.sec_inv_en);
    endfunction

    function automatic logic ninv_disabled(input auth_t a);
        return !((a.ninv_en || a.dbg_en) && (a.sec_ninv_en || a.sec_inv_en));
    endfunction

    function automatic int exc_pos(input int idx);
        case (idx)
            EX_UNDEF: return P_UNDEF;
            EX_ASYNC: return P_ASYNC;
            default:  return P_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/dbg_core_state.sv
module dbg_core_state
    import dbg_stat_pkg::*;
#(
    parameter int CW = CAUSE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          halt_req_i,
    input  logic          restart_i,
    input  logic [CW-1:0] cause_i,
    input  logic          wr_en_i,
    input  logic [CW-1:0] wr_cause_i,
    output logic          halted_o,
    output logic          restarted_o,
    output logic [CW-1:0] cause_o
);

    logic          halted_q, restarted_q;
    logic [CW-1:0] cause_q;
    logic          enter, leave;

    assign enter = halt_req_i && !halted_q;
    assign leave = restart_i && halted_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            halted_q    <= 1'b0;
            restarted_q <= 1'b1;
            cause_q     <= CW'(CAUSE_RUNCTL);
        end else begin
            if (enter) begin
                halted_q    <= 1'b1;
                restarted_q <= 1'b0;
            end else if (leave) begin
                halted_q    <= 1'b0;
                restarted_q <= 1'b1;
            end
            if (enter)
                cause_q <= cause_i;
            else if (wr_en_i)
                cause_q <= wr_cause_i;
        end
    end

    assign halted_o    = halted_q;
    assign restarted_o = restarted_q;
    assign cause_o     = cause_q;

    a_r9_state_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({halted_q, restarted_q}) == 1);
    a_r9_halt_entry: assert property (@(posedge clk) disable iff (rst)
        (halt_req_i && !halted_q) |=> halted_q);
    a_r9_restart_exit: assert property (@(posedge clk) disable iff (rst)
        (restart_i && halted_q) |=> (restarted_q && !halted_q));
    a_r10_cause_capture: assert property (@(posedge clk) disable iff (rst)
        (halt_req_i && !halted_q) |=> cause_q == $past(cause_i));

endmodule

// File: rtl/dbg_sticky_bank.sv
module dbg_sticky_bank
    import dbg_stat_pkg::*;
#(
    parameter int NE     = NUM_EXC,
    parameter int RCTL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halted_i,
    input  logic              retire_i,
    input  logic [NE-1:0]     exc_evt_i,
    input  logic              rctl_wr_i,
    input  logic [RCTL_W-1:0] rctl_data_i,
    output logic [NE-1:0]     exc_o,
    output logic              adv_o
);

    logic clr_exc, clr_adv;
    logic adv_q;

    assign clr_exc = rctl_wr_i && rctl_data_i[RC_EXC_BIT];
    assign clr_adv = rctl_wr_i && rctl_data_i[RC_ADV_BIT];

    // progress flag: a retire in the clearing cycle is kept
    always_ff @(posedge clk) begin
        if (rst)
            adv_q <= 1'b0;
        else if (retire_i)
            adv_q <= 1'b1;
        else if (clr_adv)
            adv_q <= 1'b0;
    end
    assign adv_o = adv_q;

    a_r2_retire_sets: assert property (@(posedge clk) disable iff (rst)
        retire_i |=> adv_q);
    a_r2_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_adv && !retire_i) |=> !adv_q);

    for (genvar g = 0; g < NE; g++) begin : g_exc
        logic flag_q;
        logic hit;
        assign hit = exc_evt_i[g] && halted_i;

        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (hit)
                flag_q <= 1'b1;
            else if (clr_exc)
                flag_q <= 1'b0;
        end
        assign exc_o[g] = flag_q;

        a_r3_only_in_debug: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_q) |-> $past(halted_i && exc_evt_i[g]));
        a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
            (clr_exc && !exc_evt_i[g]) |=> !flag_q);
    end

endmodule

// File: rtl/dbg_ctrl_fields.sv
module dbg_ctrl_fields
    import dbg_stat_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  auth_t        auth_i,
    output ctrl_t        ctrl_o,
    output logic         halt_en_rd_o,
    output logic         mon_en_rd_o,
    output logic         inv_dis_o,
    output logic         ninv_dis_o
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en_i)
            ctrl_q <= ctrl_from_word(wr_data_i);
    end

    assign ctrl_o       = ctrl_q;
    assign halt_en_rd_o = ctrl_q.halt_en && auth_i.dbg_en;
    assign mon_en_rd_o  = ctrl_q.mon_en  && auth_i.dbg_en;
    assign inv_dis_o    = inv_disabled(auth_i);
    assign ninv_dis_o   = ninv_disabled(auth_i);

    a_r6_gated_low: assert property (@(posedge clk) disable iff (rst)
        !auth_i.dbg_en |-> !(halt_en_rd_o || mon_en_rd_o));
    a_r6_stored_value: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[P_HALT_EN]) |=> (halt_en_rd_o || !auth_i.dbg_en));

endmodule

// File: rtl/dbg_stat_ctl.sv
module dbg_stat_ctl
    import dbg_stat_pkg::*;
#(
    parameter int RCTL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wr_data,
    input  logic              rctl_wr_en,
    input  logic [RCTL_W-1:0] rctl_wr_data,
    input  logic              retire,
    input  logic              undef_evt,
    input  logic              sync_abort,
    input  logic              async_abort,
    input  logic              halt_evt,
    input  logic [3:0]        halt_cause,
    input  logic              restart_evt,
    input  logic              dbg_en,
    input  logic              ninv_en,
    input  logic              sec_inv_en,
    input  logic              sec_ninv_en,
    input  logic              nonsecure,
    output logic [31:0]       reg_rd_data,
    output logic              irq_mask,
    output logic              dbg_ack,
    output logic              dbg_trig
);

    logic               halted, restarted;
    logic [CAUSE_W-1:0] cause;
    logic [NUM_EXC-1:0] exc_evt, exc_flags;
    logic               adv;
    ctrl_t              ctrl;
    auth_t              auth;
    logic               halt_en_rd, mon_en_rd, inv_dis, ninv_dis;

    assign auth = '{dbg_en: dbg_en, ninv_en: ninv_en,
                    sec_inv_en: sec_inv_en, sec_ninv_en: sec_ninv_en};

    always_comb begin
        exc_evt           = '0;
        exc_evt[EX_UNDEF] = undef_evt;
        exc_evt[EX_ASYNC] = async_abort;
        exc_evt[EX_SYNC]  = sync_abort;
    end

    dbg_core_state #(.CW(CAUSE_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .halt_req_i (halt_evt),
        .restart_i  (restart_evt),
        .cause_i    (halt_cause),
        .wr_en_i    (reg_wr_en),
        .wr_cause_i (reg_wr_data[P_CAUSE_LO +: CAUSE_W]),
        .halted_o   (halted),
        .restarted_o(restarted),
        .cause_o    (cause)
    );

    dbg_sticky_bank #(.NE(NUM_EXC), .RCTL_W(RCTL_W)) u_sticky (
        .clk        (clk),
        .rst        (rst),
        .halted_i   (halted),
        .retire_i   (retire),
        .exc_evt_i  (exc_evt),
        .rctl_wr_i  (rctl_wr_en),
        .rctl_data_i(rctl_wr_data),
        .exc_o      (exc_flags),
        .adv_o      (adv)
    );

    dbg_ctrl_fields #(.W(REG_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (reg_wr_en),
        .wr_data_i   (reg_wr_data),
        .auth_i      (auth),
        .ctrl_o      (ctrl),
        .halt_en_rd_o(halt_en_rd),
        .mon_en_rd_o (mon_en_rd),
        .inv_dis_o   (inv_dis),
        .ninv_dis_o  (ninv_dis)
    );

    always_comb begin
        reg_rd_data                        = '0;
        reg_rd_data[P_ADV]                 = adv;
        reg_rd_data[P_MODE_LO +: MODE_W]   = ctrl.mode;
        reg_rd_data[P_DISCARD]             = halted;
        reg_rd_data[P_NS]                  = nonsecure;
        reg_rd_data[P_NINV_DIS]            = ninv_dis;
        reg_rd_data[P_INV_DIS]             = inv_dis;
        reg_rd_data[P_MON_EN]              = mon_en_rd;
        reg_rd_data[P_HALT_EN]             = halt_en_rd;
        reg_rd_data[P_EXEC_EN]             = ctrl.exec_en;
        reg_rd_data[P_USR_DIS]             = ctrl.usr_dis;
        reg_rd_data[P_IRQ_DIS]             = ctrl.irq_dis;
        reg_rd_data[P_ACK_FRC]             = ctrl.ack_force;
        for (int i = 0; i < NUM_EXC; i++)
            reg_rd_data[exc_pos(i)]        = exc_flags[i];
        reg_rd_data[P_CAUSE_LO +: CAUSE_W] = cause;
        reg_rd_data[P_RESTART]             = restarted;
        reg_rd_data[P_HALTED]              = halted;
    end

    assign irq_mask = ctrl.irq_dis;
    assign dbg_ack  = ctrl.ack_force || halted;
    assign dbg_trig = ctrl.ack_force || halted;

    a_r8_force_drives: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_data[P_ACK_FRC]) |=> (dbg_ack && dbg_trig));
    a_r12_mask_follows_write: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> irq_mask == $past(reg_wr_data[P_IRQ_DIS]));
    a_r5_discard_tracks_halt: assert property (@(posedge clk) disable iff (rst)
        (halt_evt && !reg_rd_data[P_HALTED]) |=> reg_rd_data[P_DISCARD]);
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[31:26] == 6'd0 && !reg_rd_data[24] &&
        reg_rd_data[23:22] == 2'd0 && !reg_rd_data[9]);

endmodule

// File: tb/test_dbg_stat_ctl.sv
module test_dbg_stat_ctl;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic        rctl_wr_en;
    logic [31:0] rctl_wr_data;
    logic        retire, undef_evt, sync_abort, async_abort;
    logic        halt_evt, restart_evt;
    logic [3:0]  halt_cause;
    logic        dbg_en, ninv_en, sec_inv_en, sec_ninv_en, nonsecure;
    logic [31:0] reg_rd_data;
    logic        irq_mask, dbg_ack, dbg_trig;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dbg_stat_ctl #(.RCTL_W(32)) i_dbg_stat_ctl (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .rctl_wr_en(rctl_wr_en), .rctl_wr_data(rctl_wr_data),
        .retire(retire), .undef_evt(undef_evt), .sync_abort(sync_abort),
        .async_abort(async_abort), .halt_evt(halt_evt), .halt_cause(halt_cause),
        .restart_evt(restart_evt), .dbg_en(dbg_en), .ninv_en(ninv_en),
        .sec_inv_en(sec_inv_en), .sec_ninv_en(sec_ninv_en), .nonsecure(nonsecure),
        .reg_rd_data(reg_rd_data), .irq_mask(irq_mask),
        .dbg_ack(dbg_ack), .dbg_trig(dbg_trig)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one clock edge, then settle
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        reg_wr_en = 0; reg_wr_data = '0; rctl_wr_en = 0; rctl_wr_data = '0;
        retire = 0; undef_evt = 0; sync_abort = 0; async_abort = 0;
        halt_evt = 0; restart_evt = 0; halt_cause = '0;
    endtask

    task automatic wr_reg(input logic [31:0] d);
        reg_wr_en = 1; reg_wr_data = d; step(); reg_wr_en = 0; reg_wr_data = '0;
    endtask

    task automatic wr_rctl(input logic [31:0] d);
        rctl_wr_en = 1; rctl_wr_data = d; step(); rctl_wr_en = 0; rctl_wr_data = '0;
    endtask

    task automatic t_reset();
        chk("R1 read word", reg_rd_data, 32'h0000_0002);
        chk("R1 outputs", {29'd0, irq_mask, dbg_ack, dbg_trig}, 32'd0);
    endtask

    task automatic t_write_fields();
        wr_reg(32'hFFFF_FFFF);
        chk("R11 writable fields only", reg_rd_data, 32'h0030_FC3E);
        chk("R12 irq mask set", {31'd0, irq_mask}, 32'd1);
        chk("R8 forced ack/trig", {30'd0, dbg_ack, dbg_trig}, 32'd3);
        wr_reg(32'h0000_0000);
        chk("R11 cleared", reg_rd_data, 32'h0000_0002);
        chk("R8 ack/trig follow halted", {30'd0, dbg_ack, dbg_trig}, 32'd0);
        wr_reg(32'h0000_0800);
        chk("R12 irq mask alone", {31'd0, irq_mask}, 32'd1);
        wr_reg(32'h0000_0000);
    endtask

    task automatic t_auth();
        wr_reg(32'h0000_C000);
        chk("R6 enables visible", reg_rd_data, 32'h0000_C002);
        dbg_en = 0; #1;
        chk("R6 masked, R7 inv disabled", reg_rd_data, 32'h0001_0002);
        dbg_en = 1; #1;
        chk("R6 restored", reg_rd_data, 32'h0000_C002);
        sec_inv_en = 0; ninv_en = 0; #1;
        chk("R7 sec invasive off", reg_rd_data, 32'h0001_C002);
        dbg_en = 0; #1;
        chk("R7 both disabled", reg_rd_data, 32'h0003_0002);
        sec_ninv_en = 0; ninv_en = 1; dbg_en = 1; #1;
        chk("R7 no secure enables", reg_rd_data, 32'h0003_C002);
        dbg_en = 1; ninv_en = 1; sec_inv_en = 1; sec_ninv_en = 1;
        nonsecure = 1; #1;
        chk("R13 nonsecure", reg_rd_data, 32'h0004_C002);
        nonsecure = 0;
        wr_reg(32'h0000_0000);
    endtask

    task automatic t_halt_and_sticky();
        undef_evt = 1; sync_abort = 1; async_abort = 1; step();
        undef_evt = 0; sync_abort = 0; async_abort = 0;
        chk("R3 ignored outside debug", reg_rd_data, 32'h0000_0002);
        halt_evt = 1; halt_cause = 4'b0100; step(); halt_evt = 0;
        chk("R9/R10/R5 halt entry", reg_rd_data, 32'h0008_0011);
        chk("R8 ack follows halted", {30'd0, dbg_ack, dbg_trig}, 32'd3);
        halt_evt = 1; halt_cause = 4'b0101; step(); halt_evt = 0;
        chk("R9/R10 second halt ignored", reg_rd_data, 32'h0008_0011);
        undef_evt = 1; step(); undef_evt = 0;
        chk("R3 undef flag", reg_rd_data, 32'h0008_0111);
        async_abort = 1; step(); async_abort = 0;
        chk("R5 async flag while discarding", reg_rd_data, 32'h0008_0191);
        sync_abort = 1; step(); sync_abort = 0;
        chk("R3 sync flag", reg_rd_data, 32'h0008_01D1);
        wr_rctl(32'h0000_0008);
        chk("R4 bit3 keeps exc flags", reg_rd_data, 32'h0008_01D1);
        wr_rctl(32'h0000_0004);
        chk("R4 bit2 clears exc flags", reg_rd_data, 32'h0008_0011);
        sync_abort = 1; rctl_wr_en = 1; rctl_wr_data = 32'h4; step();
        sync_abort = 0; rctl_wr_en = 0; rctl_wr_data = '0;
        chk("R3 set beats clear", reg_rd_data, 32'h0008_0051);
        wr_rctl(32'h0000_0004);
        restart_evt = 1; step(); restart_evt = 0;
        chk("R9/R5 restart", reg_rd_data, 32'h0000_0012);
        chk("R8 ack low after exit", {30'd0, dbg_ack, dbg_trig}, 32'd0);
        restart_evt = 1; step(); restart_evt = 0;
        chk("R9 restart ignored when running", reg_rd_data, 32'h0000_0012);
        undef_evt = 1; async_abort = 1; step(); undef_evt = 0; async_abort = 0;
        chk("R3 no flags after exit", reg_rd_data, 32'h0000_0012);
    endtask

    task automatic t_progress();
        retire = 1; step(); retire = 0;
        chk("R2 retire sets", reg_rd_data, 32'h0200_0012);
        wr_rctl(32'h0000_0004);
        chk("R4 bit2 keeps progress", reg_rd_data, 32'h0200_0012);
        wr_rctl(32'hFFFF_FFF0);
        chk("R2 upper bits no effect", reg_rd_data, 32'h0200_0012);
        retire = 1; rctl_wr_en = 1; rctl_wr_data = 32'h8; step();
        retire = 0; rctl_wr_en = 0; rctl_wr_data = '0;
        chk("R2 set beats clear", reg_rd_data, 32'h0200_0012);
        wr_rctl(32'h0000_0008);
        chk("R2 bit3 clears", reg_rd_data, 32'h0000_0012);
    endtask

    task automatic t_cause();
        wr_reg(32'h0000_0028);
        chk("R10 cause writable", reg_rd_data, 32'h0000_002A);
        halt_evt = 1; halt_cause = 4'b0001;
        reg_wr_en = 1; reg_wr_data = 32'h0000_0014; step();
        halt_evt = 0; reg_wr_en = 0; reg_wr_data = '0;
        chk("R10 halt beats write", reg_rd_data, 32'h0008_0005);
    endtask

    initial begin
        idle_inputs();
        dbg_en = 1; ninv_en = 1; sec_inv_en = 1; sec_ninv_en = 1; nonsecure = 0;
        rst = 1;
        repeat (3) step();
        rst = 0;
        #1;
        t_reset();
        t_write_fields();
        t_auth();
        t_halt_and_sticky();
        t_progress();
        t_cause();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule